// File: doc/BRIEF.md
# Two-way page translation cache

This block caches recent page translations in front of a hashed page-table walker. Each cached entry pairs a virtual page tag with the second word of a page-table entry. That word supplies the physical frame, the change bit and the memory attribute bits. Instruction fetches and data accesses are looked up in two separate arrays. Each array is two-way set-associative and keeps one recency bit per set.

A lookup names an effective address and an access kind. One cycle later the block returns one of three results: hit, miss, or a change-bit update request. On a hit it also returns the physical address and a flag that marks the page as write-through or cache-inhibited. The walker answers a miss with a fill. A software invalidate names an address and clears the matching set in both arrays. Probe lookups let a debugger or an optimiser ask about a page without disturbing the replacement state.

Top module: `tlb2_top`

## Requirements
- R1: After reset every way in both arrays holds the invalid marker, so the first lookup of any page misses. `rsp_valid` is low while reset is applied.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and never otherwise. While it is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_upd_c` is set. While it is low, all three are clear.
- R3: The page tag is `ea[31:12]` and the set is the low four bits of that tag. A lookup hits when a way of the selected set holds that tag; way 0 wins if both ways match. On a hit, `rsp_pa` is `{pte[31:12], ea[11:0]}`. On a miss or an update request, `rsp_pa` and `rsp_wi` are zero.
- R4: Kind codes are 0 read, 1 write, 2 fetch, 3 data probe and 4 instruction probe; codes 5 to 7 act as data probes. Kinds 2 and 4 use the instruction array and all other kinds use the data array. A fill goes to the array of its kind.
- R5: A write lookup that matches an entry whose change bit (PTE bit 7) is 0 returns `rsp_upd_c` instead of a hit and sets the stored change bit. The next write to that page is a plain hit.
- R6: A plain hit by a read, write or fetch sets the set's recency bit to the way that hit. A probe hit, a miss and an update request leave it unchanged.
- R7: A fill writes way 1 when the recency bit is 0 and way 0 holds a valid tag, and writes way 0 otherwise. The recency bit then takes the number of the way written.
- R8: A fill whose kind is a probe code has no effect.
- R9: An invalidate clears both ways of the addressed set in both arrays and resets that set's recency bit to 0.
- R10: `rsp_wi` is set on a hit when PTE bit 6 or PTE bit 5 of the entry is set.
- R11: The all-ones page (`ea[31:12]` all ones) never hits, even after a fill for it.
- R12: When several commands touch the same set in the same cycle, an invalidate takes precedence over a fill, and a fill takes precedence over the side effects of a lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 3 | Lookup access kind |
| lk_ea | input | 32 | Lookup effective address |
| fill_valid | input | 1 | Fill request |
| fill_kind | input | 3 | Access kind that caused the fill |
| fill_ea | input | 32 | Effective address of the filled page |
| fill_pte | input | 32 | Second page-table-entry word |
| inv_valid | input | 1 | Invalidate-by-address request |
| inv_ea | input | 32 | Address whose set is invalidated |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Plain hit |
| rsp_miss | output | 1 | Miss |
| rsp_upd_c | output | 1 | Hit that requires a change-bit write-back |
| rsp_pa | output | 32 | Physical address on a hit |
| rsp_wi | output | 1 | Write-through or cache-inhibited page |

## Verification
The bound checker checks the response protocol on every cycle. That covers the one-cycle timing of the strobe and the single result per response. It also checks that the page offset passes through on a hit, that update requests come only from writes, that the all-ones page never hits, and that a response which is not a hit carries zero attributes. Replacement order, the recency effect of probes, the separation of the two arrays, the change-bit handshake and invalidate priority depend on stored history. Only the bench's directed sequences and its reference-model random traffic show those.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  typedef enum logic [2:0] {
    K_READ    = 3'd0,
    K_WRITE   = 3'd1,
    K_FETCH   = 3'd2,
    K_PROBE_D = 3'd3,
    K_PROBE_I = 3'd4
  } acc_kind_e;

  localparam int PTE_C_BIT = 7;
  localparam int PTE_W_BIT = 6;
  localparam int PTE_I_BIT = 5;

  function automatic logic kind_is_inst(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_PROBE_I);
  endfunction

  function automatic logic kind_is_probe(input logic [2:0] k);
    return !((k == K_READ) || (k == K_WRITE) || (k == K_FETCH));
  endfunction
endpackage

// File: rtl/tlb2_bank.sv
module tlb2_bank
  import tlb2_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int IDX_W = 4,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_write,
  input  logic             lk_probe,
  input  logic             fl_en,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic [PTE_W-1:0] fl_pte,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  output logic             hit_o,
  output logic             updc_o,
  output logic [PTE_W-1:0] pte_o
);
  localparam int SETS = 1 << IDX_W;
  localparam logic [TAG_W-1:0] TAG_NONE = '1;

  logic [1:0][TAG_W-1:0] tag_q [SETS];
  logic [1:0][TAG_W-1:0] tag_d [SETS];
  logic [1:0][PTE_W-1:0] pte_q [SETS];
  logic [1:0][PTE_W-1:0] pte_d [SETS];
  logic [SETS-1:0]       rec_q, rec_d, set_en;

  // lookup against the state before the edge
  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic             m0, m1, hit_any, hway, c_clear, fway;
  logic [PTE_W-1:0] hpte;

  always_comb begin
    lk_idx  = lk_tag[IDX_W-1:0];
    m0      = (lk_tag != TAG_NONE) && (tag_q[lk_idx][0] == lk_tag);
    m1      = (lk_tag != TAG_NONE) && (tag_q[lk_idx][1] == lk_tag) && !m0;
    hit_any = m0 || m1;
    hway    = !m0;
    hpte    = m0 ? pte_q[lk_idx][0] : pte_q[lk_idx][1];
    c_clear = lk_write && !hpte[PTE_C_BIT];
    hit_o   = lk_en && hit_any && !c_clear;
    updc_o  = lk_en && hit_any && c_clear;
    pte_o   = hpte;
    fl_idx  = fl_tag[IDX_W-1:0];
    fway    = !rec_q[fl_idx] && (tag_q[fl_idx][0] != TAG_NONE);
  end

  // next state per set: invalidate, then fill, then lookup side effects
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      tag_d[s]  = tag_q[s];
      pte_d[s]  = pte_q[s];
      rec_d[s]  = rec_q[s];
      set_en[s] = 1'b0;
      if (inv_en && (inv_idx == IDX_W'(s))) begin
        tag_d[s]  = {TAG_NONE, TAG_NONE};
        rec_d[s]  = 1'b0;
        set_en[s] = 1'b1;
      end else if (fl_en && (fl_idx == IDX_W'(s))) begin
        tag_d[s][fway] = fl_tag;
        pte_d[s][fway] = fl_pte;
        rec_d[s]       = fway;
        set_en[s]      = 1'b1;
      end else if (lk_en && hit_any && (lk_idx == IDX_W'(s))) begin
        if (c_clear) begin
          pte_d[s][hway][PTE_C_BIT] = 1'b1;
          set_en[s]                 = 1'b1;
        end else if (!lk_probe) begin
          rec_d[s]  = hway;
          set_en[s] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= {TAG_NONE, TAG_NONE};
        pte_q[s] <= '0;
      end
      rec_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (set_en[s]) begin
          tag_q[s] <= tag_d[s];
          pte_q[s] <= pte_d[s];
          rec_q[s] <= rec_d[s];
        end
      end
    end
  end
endmodule

// File: rtl/tlb2_top.sv
module tlb2_top
  import tlb2_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [2:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_ea,
  input  logic              fill_valid,
  input  logic [2:0]        fill_kind,
  input  logic [ADDR_W-1:0] fill_ea,
  input  logic [ADDR_W-1:0] fill_pte,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_ea,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_upd_c,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_wi
);
  localparam int TAG_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  logic [1:0]             bk_hit, bk_updc;
  logic [1:0][ADDR_W-1:0] bk_pte;
  logic                   lk_inst, fl_inst, fl_ok;

  assign lk_inst = kind_is_inst(lk_kind);
  assign fl_inst = kind_is_inst(fill_kind);
  assign fl_ok   = fill_valid && !kind_is_probe(fill_kind);

  // bank 0 serves data accesses, bank 1 instruction fetches
  for (genvar b = 0; b < 2; b++) begin : g_bank
    tlb2_bank #(.TAG_W(TAG_W), .IDX_W(IDX_W), .PTE_W(ADDR_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (lk_valid && (lk_inst == 1'(b))),
      .lk_tag   (lk_ea[ADDR_W-1:PAGE_SHIFT]),
      .lk_write (lk_kind == K_WRITE),
      .lk_probe (kind_is_probe(lk_kind)),
      .fl_en    (fl_ok && (fl_inst == 1'(b))),
      .fl_tag   (fill_ea[ADDR_W-1:PAGE_SHIFT]),
      .fl_pte   (fill_pte),
      .inv_en   (inv_valid),
      .inv_idx  (inv_ea[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT]),
      .hit_o    (bk_hit[b]),
      .updc_o   (bk_updc[b]),
      .pte_o    (bk_pte[b])
    );
  end

  logic              hit_n, upd_n, miss_n, wi_n;
  logic [ADDR_W-1:0] sel_pte, pa_n;

  always_comb begin
    sel_pte = bk_pte[lk_inst];
    hit_n   = bk_hit[lk_inst];
    upd_n   = bk_updc[lk_inst];
    miss_n  = lk_valid && !hit_n && !upd_n;
    pa_n    = hit_n ? ((sel_pte & ~OFS_MASK) | (lk_ea & OFS_MASK)) : '0;
    wi_n    = hit_n && (sel_pte[PTE_W_BIT] || sel_pte[PTE_I_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_upd_c <= 1'b0;
      rsp_pa    <= '0;
      rsp_wi    <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_n;
      rsp_miss  <= miss_n;
      rsp_upd_c <= upd_n;
      if (lk_valid) begin
        rsp_pa <= pa_n;
        rsp_wi <= wi_n;
      end
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{fill_ea[PAGE_SHIFT-1:0], inv_ea[PAGE_SHIFT-1:0],
                              inv_ea[ADDR_W-1:PAGE_SHIFT+IDX_W]};
endmodule

// File: rtl/tlb2_chk.sv
module tlb2_chk
  import tlb2_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [2:0]        lk_kind,
  input logic [ADDR_W-1:0] lk_ea,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_upd_c,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic              rsp_wi
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r2_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_upd_c}));
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_upd_c));
  a_r3_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_pa[PAGE_SHIFT-1:0] == $past(lk_ea[PAGE_SHIFT-1:0])));
  a_r5_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind != K_WRITE) |=> !rsp_upd_c);
  a_r11_marker_page: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (&lk_ea[ADDR_W-1:PAGE_SHIFT])) |=> (rsp_miss && !rsp_hit));
  a_r10_attr_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_wi && rsp_pa == '0));
endmodule

bind tlb2_top tlb2_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) i_tlb2_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_kind   (lk_kind),
  .lk_ea     (lk_ea),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_upd_c (rsp_upd_c),
  .rsp_pa    (rsp_pa),
  .rsp_wi    (rsp_wi)
);

// File: tb/test_tlb2_top.sv
`timescale 1ns/1ps
module test_tlb2_top;
  localparam int SETS = 16;
  localparam logic [19:0] NONE = '1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_valid, inv_valid;
  logic [2:0]  lk_kind, fill_kind;
  logic [31:0] lk_ea, fill_ea, fill_pte, inv_ea;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_upd_c, rsp_wi;
  logic [31:0] rsp_pa;

  tlb2_top i_tlb2_top (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_ea(lk_ea),
    .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_ea(fill_ea), .fill_pte(fill_pte),
    .inv_valid(inv_valid), .inv_ea(inv_ea),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_upd_c(rsp_upd_c), .rsp_pa(rsp_pa), .rsp_wi(rsp_wi)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [19:0] m_tag [2][SETS][2];
  logic [31:0] m_pte [2][SETS][2];
  bit          m_rec [2][SETS];

  function automatic bit inst_of(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

  function automatic bit probe_of(input logic [2:0] k);
    return k > 3'd2;
  endfunction

  function automatic void m_clear_set(input int s);
    for (int b = 0; b < 2; b++) begin
      m_tag[b][s][0] = NONE;
      m_tag[b][s][1] = NONE;
      m_rec[b][s]    = 1'b0;
    end
  endfunction

  function automatic void m_fill(input logic [2:0] k, input logic [31:0] ea, input logic [31:0] pte);
    int b, s, w;
    if (probe_of(k)) return;
    b = inst_of(k) ? 1 : 0;
    s = int'(ea[15:12]);
    w = (!m_rec[b][s] && m_tag[b][s][0] != NONE) ? 1 : 0;
    m_tag[b][s][w] = ea[31:12];
    m_pte[b][s][w] = pte;
    m_rec[b][s]    = (w == 1);
  endfunction

  task automatic check(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [2:0] k, input logic [31:0] ea, input string r);
    int b, s, w;
    bit eh, eu, em, ewi;
    logic [31:0] epa;
    b = inst_of(k) ? 1 : 0;
    s = int'(ea[15:12]);
    eh = 0; eu = 0; em = 0; ewi = 0; epa = '0; w = -1;
    if (ea[31:12] != NONE) begin
      if (m_tag[b][s][0] == ea[31:12]) w = 0;
      else if (m_tag[b][s][1] == ea[31:12]) w = 1;
    end
    if (w < 0) em = 1;
    else if (k == 3'd1 && !m_pte[b][s][w][7]) begin
      eu = 1;
      m_pte[b][s][w][7] = 1'b1;
    end else begin
      eh  = 1;
      epa = {m_pte[b][s][w][31:12], ea[11:0]};
      ewi = m_pte[b][s][w][6] | m_pte[b][s][w][5];
      if (!probe_of(k)) m_rec[b][s] = (w == 1);
    end
    lk_valid = 1'b1; lk_kind = k; lk_ea = ea;
    @(negedge clk);
    lk_valid = 1'b0;
    check(r, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(r, "rsp_hit",   32'(rsp_hit),   32'(eh));
    check(r, "rsp_upd_c", 32'(rsp_upd_c), 32'(eu));
    check(r, "rsp_miss",  32'(rsp_miss),  32'(em));
    check(r, "rsp_pa",    rsp_pa,         epa);
    check(r, "rsp_wi",    32'(rsp_wi),    32'(ewi));
  endtask

  task automatic do_fill(input logic [2:0] k, input logic [31:0] ea, input logic [31:0] pte);
    m_fill(k, ea, pte);
    fill_valid = 1'b1; fill_kind = k; fill_ea = ea; fill_pte = pte;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv(input logic [31:0] ea);
    m_clear_set(int'(ea[15:12]));
    inv_valid = 1'b1; inv_ea = ea;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < SETS; s++) m_clear_set(s);
    rst_n = 1'b0; lk_valid = 0; fill_valid = 0; inv_valid = 0;
    lk_kind = 0; fill_kind = 0; lk_ea = 0; fill_ea = 0; fill_pte = 0; inv_ea = 0;
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    do_lookup(3'd0, 32'h0001_0123, "R1");
    do_lookup(3'd2, 32'h0002_3456, "R1");
    do_lookup(3'd1, 32'h0000_0000, "R1");

    // R2: no response without a lookup
    do_fill(3'd0, 32'h0005_5000, 32'h1234_5080);
    check("R2", "rsp_valid after fill", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);

    // R7: replacement order in set 5
    do_inv(32'h0000_5000);
    do_fill(3'd0, 32'h0001_5000, 32'hA000_0080);
    do_fill(3'd0, 32'h0002_5000, 32'hB000_0080);
    do_fill(3'd0, 32'h0003_5000, 32'hC000_0080);
    do_lookup(3'd0, 32'h0001_5abc, "R7");
    do_lookup(3'd0, 32'h0002_5abc, "R7");
    do_lookup(3'd0, 32'h0003_5abc, "R7");

    // R6: hit updates recency, probe does not
    do_inv(32'h0000_6000);
    do_fill(3'd0, 32'h0001_6000, 32'h1100_0080);
    do_fill(3'd0, 32'h0002_6000, 32'h2200_0080);
    do_lookup(3'd0, 32'h0001_6004, "R6");
    do_fill(3'd0, 32'h0003_6000, 32'h3300_0080);
    do_lookup(3'd0, 32'h0002_6008, "R6");
    do_lookup(3'd0, 32'h0001_6008, "R6");
    do_inv(32'h0000_7000);
    do_fill(3'd0, 32'h0001_7000, 32'h4400_0080);
    do_fill(3'd0, 32'h0002_7000, 32'h5500_0080);
    do_lookup(3'd3, 32'h0001_7010, "R6");
    do_fill(3'd0, 32'h0003_7000, 32'h6600_0080);
    do_lookup(3'd0, 32'h0001_7010, "R6");
    do_lookup(3'd0, 32'h0002_7010, "R6");

    // R5: change-bit handshake
    do_fill(3'd0, 32'h0004_8000, 32'h7700_0000);
    do_lookup(3'd0, 32'h0004_8020, "R5");
    do_lookup(3'd1, 32'h0004_8020, "R5");
    do_lookup(3'd1, 32'h0004_8024, "R5");

    // R4: separate arrays
    do_fill(3'd0, 32'h0004_9000, 32'h8800_0080);
    do_lookup(3'd2, 32'h0004_9000, "R4");
    do_lookup(3'd4, 32'h0004_9000, "R4");
    do_lookup(3'd0, 32'h0004_9000, "R4");
    do_fill(3'd2, 32'h0005_9000, 32'h9900_0080);
    do_lookup(3'd2, 32'h0005_9ffc, "R4");
    do_lookup(3'd0, 32'h0005_9ffc, "R4");
    do_lookup(3'd6, 32'h0004_9000, "R4");

    // R10: attribute bits
    do_fill(3'd0, 32'h0001_c000, 32'hAB00_00C0);
    do_fill(3'd0, 32'h0001_d000, 32'hAC00_00A0);
    do_fill(3'd0, 32'h0001_e000, 32'hAD00_0098);
    do_lookup(3'd0, 32'h0001_c001, "R10");
    do_lookup(3'd0, 32'h0001_d002, "R10");
    do_lookup(3'd0, 32'h0001_e003, "R10");

    // R11: all-ones page
    do_fill(3'd0, 32'hFFFF_F000, 32'h1111_1080);
    do_lookup(3'd0, 32'hFFFF_F123, "R11");

    // R8: probe fills ignored
    do_fill(3'd3, 32'h0006_4000, 32'h2222_2080);
    do_fill(3'd4, 32'h0006_4000, 32'h3333_3080);
    do_lookup(3'd0, 32'h0006_4000, "R8");
    do_lookup(3'd2, 32'h0006_4000, "R8");

    // R9: invalidate both arrays
    do_fill(3'd0, 32'h0007_a000, 32'h4444_4080);
    do_fill(3'd2, 32'h0008_a000, 32'h5555_5080);
    do_inv(32'h1234_a777);
    do_lookup(3'd0, 32'h0007_a000, "R9");
    do_lookup(3'd2, 32'h0008_a000, "R9");

    // R12: invalidate beats fill on the same set
    m_fill(3'd0, 32'h0009_b000, 32'h6666_6080);
    m_clear_set(11);
    fill_valid = 1; fill_kind = 3'd0; fill_ea = 32'h0009_b000; fill_pte = 32'h6666_6080;
    inv_valid = 1; inv_ea = 32'h0000_b000;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0;
    do_lookup(3'd0, 32'h0009_b000, "R12");

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [31:0] ea;
      op = int'($urandom % 100);
      ea = {16'(($urandom % 3) + 1), 4'($urandom % 4), 12'($urandom)};
      if (($urandom % 32) == 0) ea[31:12] = NONE;
      if (op < 50) do_lookup(3'($urandom % 5), ea, "R3");
      else if (op < 85) do_fill(3'($urandom % 5), ea, $urandom);
      else if (op < 92) do_inv(ea);
      else @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule